// File: doc/BRIEF.md
# Zero-Crossing Stereo Volume Attenuator

This block applies a per-channel digital volume setting to a signed PCM sample stream just before the converter. Each setting is a 6-bit attenuation code in 1.5 dB steps, from 0 dB down to -94.5 dB, plus a mute bit that forces the output to zero. The block sits after any digital mix summation. Mixed material therefore passes through this attenuation as well.

A new setting is requested by driving the request inputs of a channel. The change does not take effect straight away. It waits until that channel's signal crosses zero, so the gain never steps in the middle of a waveform. If no crossing comes, a sample-count timeout forces the change through. Every channel has its own crossing detector, timer and active-setting register, so one channel never waits on another.

Samples enter as a parallel word per channel, qualified by one common strobe. The attenuated words come out one cycle later, with a valid pulse. The active settings are visible on their own outputs.

Top module: `zc_vol_atten`

## Requirements
- R1: After reset, every channel's active code is 0 (0 dB), its active mute bit is 0, `out_vld` is 0 and `out_data` is all zero.
- R2: For an unmuted active code c, the output word is floor(s * M / 2^(15 + c/4)), where s is the signed input sample, c/4 is integer division, and M is 32768, 27571, 23198 or 19519 for c mod 4 = 0, 1, 2 or 3. M is 2^15 * 10^(-1.5*(c mod 4)/20), rounded to the nearest integer.
- R3: While a channel's active mute bit is 1, its output word is 0 whatever the code and the sample.
- R4: A crossing on a channel is seen on a strobed sample in two cases: its sign bit (bit DATA_W-1) differs from that of the channel's previous strobed sample, or the sample is exactly zero. The previous sample is zero after reset. A pending request is made active on the strobe at which the crossing is seen, and that sample is already processed with the new setting.
- R5: A pending request leaves the active setting unchanged on strobes that show no crossing and end no timeout, and in every cycle without a strobe.
- R6: A request is pending while the requested code or mute bit differs from the active one. If TIMEOUT_SMPL strobes pass with the request pending and no crossing, the request is made active on the TIMEOUT_SMPL-th of them (default 384, which is 8 ms at 48 kHz).
- R7: Changing the request while one is pending replaces it without restarting the timer. The latest request becomes active at the deadline of the first.
- R8: Setting the request back equal to the active setting clears the pending state and the timer. A later request then gets a full TIMEOUT_SMPL-strobe window.
- R9: Channels are independent. A crossing, timeout or request on one channel never changes another channel's active setting.
- R10: `out_vld` is 1 in exactly the cycle after each cycle in which `in_stb` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Sample strobe, common to all channels |
| in_data | input | NCH*DATA_W | Signed input samples, channel c at bits [c*DATA_W +: DATA_W] |
| req_code | input | NCH*CODE_W | Requested attenuation code per channel |
| req_mute | input | NCH | Requested mute per channel |
| out_data | output | NCH*DATA_W | Attenuated signed samples |
| out_vld | output | 1 | Output word valid |
| act_code | output | NCH*CODE_W | Active attenuation code per channel |
| act_mute | output | NCH | Active mute per channel |

## Verification
The bench builds the block with two 16-bit channels, 6-bit codes and TIMEOUT_SMPL set to 8. This lets it sweep all 64 codes on both channels against a set of extreme and ordinary samples. The short timeout brings the forced-change deadline, the replacement of a request mid-window and a withdrawn request within a handful of strobes. Driving the two channels with different codes and crossing patterns shows that they keep separate pending states.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int MANT_FRAC = 15;

  // Q1.15 gain for the sub-6 dB part of a code (0, -1.5, -3, -4.5 dB)
  function automatic logic [15:0] mant_q15(input logic [1:0] fine);
    case (fine)
      2'd0:    return 16'd32768;
      2'd1:    return 16'd27571;
      2'd2:    return 16'd23198;
      default: return 16'd19519;
    endcase
  endfunction
endpackage

// File: rtl/zcv_zc_detect.sv
module zcv_zc_detect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [DATA_W-1:0] sample,
  output logic              zc
);
  logic [DATA_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= '0;
    else if (stb) prev_q <= sample;
  end

  assign zc = (sample[DATA_W-1] ^ prev_q[DATA_W-1]) || (sample == '0);
endmodule

// File: rtl/zcv_timeout.sv
module zcv_timeout #(
  parameter int TIMEOUT_SMPL = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic pend,
  input  logic zc,
  output logic expire
);
  localparam int TW = (TIMEOUT_SMPL > 2) ? $clog2(TIMEOUT_SMPL) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_SMPL - 1);

  logic [TW-1:0] cnt_q;

  assign expire = pend && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!pend)             cnt_q <= '0;
    else if (stb) begin
      if (zc || expire)         cnt_q <= '0;
      else                      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/zcv_gain.sv
module zcv_gain #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [DATA_W-1:0] sample,
  input  logic [CODE_W-1:0] code,
  input  logic              mute,
  output logic [DATA_W-1:0] y
);
  import zcv_pkg::*;
  localparam int PW = DATA_W + 17;

  function automatic logic [DATA_W-1:0] atten(input logic [DATA_W-1:0] s,
                                              input logic [CODE_W-1:0] c);
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] m;
    int sh;
    m  = PW'($signed({1'b0, mant_q15(c[1:0])}));
    p  = PW'($signed(s)) * m;
    sh = MANT_FRAC + int'(c[CODE_W-1:2]);
    p  = p >>> sh;
    return p[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y <= '0;
    else if (stb) y <= mute ? '0 : atten(sample, code);
  end
endmodule

// File: rtl/zc_vol_atten.sv
module zc_vol_atten #(
  parameter int NCH          = 2,
  parameter int DATA_W       = 16,
  parameter int CODE_W       = 6,
  parameter int TIMEOUT_SMPL = 384
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_stb,
  input  logic [NCH*DATA_W-1:0] in_data,
  input  logic [NCH*CODE_W-1:0] req_code,
  input  logic [NCH-1:0]        req_mute,
  output logic [NCH*DATA_W-1:0] out_data,
  output logic                  out_vld,
  output logic [NCH*CODE_W-1:0] act_code,
  output logic [NCH-1:0]        act_mute
);
  logic [NCH-1:0] zc_evt;
  logic [NCH-1:0] tmo_evt;
  logic [NCH-1:0] apply_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_stb;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] smp;
    logic [CODE_W-1:0] rq_code, ac_code, ef_code;
    logic              rq_mute, ac_mute, ef_mute, pend;

    assign smp     = in_data[c*DATA_W +: DATA_W];
    assign rq_code = req_code[c*CODE_W +: CODE_W];
    assign rq_mute = req_mute[c];
    assign pend    = (rq_code != ac_code) || (rq_mute != ac_mute);

    zcv_zc_detect #(.DATA_W(DATA_W)) u_zc (
      .clk(clk), .rst_n(rst_n), .stb(in_stb), .sample(smp), .zc(zc_evt[c])
    );

    zcv_timeout #(.TIMEOUT_SMPL(TIMEOUT_SMPL)) u_tmo (
      .clk(clk), .rst_n(rst_n), .stb(in_stb), .pend(pend),
      .zc(zc_evt[c]), .expire(tmo_evt[c])
    );

    assign apply_evt[c] = in_stb && pend && (zc_evt[c] || tmo_evt[c]);
    assign ef_code      = apply_evt[c] ? rq_code : ac_code;
    assign ef_mute      = apply_evt[c] ? rq_mute : ac_mute;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ac_code <= '0;
        ac_mute <= 1'b0;
      end else if (apply_evt[c]) begin
        ac_code <= rq_code;
        ac_mute <= rq_mute;
      end
    end

    zcv_gain #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_gain (
      .clk(clk), .rst_n(rst_n), .stb(in_stb), .sample(smp),
      .code(ef_code), .mute(ef_mute), .y(out_data[c*DATA_W +: DATA_W])
    );

    assign act_code[c*CODE_W +: CODE_W] = ac_code;
    assign act_mute[c]                  = ac_mute;
  end
endmodule

module zcv_checker #(
  parameter int NCH    = 2,
  parameter int DATA_W = 16,
  parameter int CODE_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_stb,
  input logic                  out_vld,
  input logic [NCH*DATA_W-1:0] out_data,
  input logic [NCH*CODE_W-1:0] act_code,
  input logic [NCH-1:0]        act_mute,
  input logic [NCH-1:0]        zc_evt,
  input logic [NCH-1:0]        tmo_evt
);
  a_r10_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> out_vld);
  a_r10_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> !out_vld);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> ($stable(act_code) && $stable(act_mute)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r3_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && act_mute[c]) |-> (out_data[c*DATA_W +: DATA_W] == '0));
    a_r4_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_code[c*CODE_W +: CODE_W]) || !$stable(act_mute[c]))
        |-> ($past(in_stb) && $past(zc_evt[c] || tmo_evt[c])));
  end
endmodule

bind zc_vol_atten zcv_checker #(.NCH(NCH), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_zcv_chk (
  .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .out_vld(out_vld),
  .out_data(out_data), .act_code(act_code), .act_mute(act_mute),
  .zc_evt(zc_evt), .tmo_evt(tmo_evt)
);

// File: tb/zc_vol_atten_bench.sv
module zc_vol_atten_bench;
  localparam int NCH = 2, DW = 16, CW = 6, TO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_stb = 1'b0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH*CW-1:0] req_code = '0;
  logic [NCH-1:0]    req_mute = '0;
  logic [NCH*DW-1:0] out_data;
  logic              out_vld;
  logic [NCH*CW-1:0] act_code;
  logic [NCH-1:0]    act_mute;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  zc_vol_atten #(.NCH(NCH), .DATA_W(DW), .CODE_W(CW), .TIMEOUT_SMPL(TO)) u_zc_vol_atten (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_data(in_data),
    .req_code(req_code), .req_mute(req_mute), .out_data(out_data),
    .out_vld(out_vld), .act_code(act_code), .act_mute(act_mute)
  );

  function automatic longint expv(longint s, int code);
    int r = code % 4;
    int k = code / 4;
    longint m = longint'($floor(32768.0 * (10.0 ** (-1.5 * r / 20.0)) + 0.5));
    longint p = s * m;
    longint d = longint'(1) << (15 + k);
    longint q = p / d;
    if (p < 0 && (p % d) != 0) q = q - 1;
    return q;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint outw(int c);
    return longint'($signed(out_data[c*DW +: DW]));
  endfunction

  function automatic int acode(int c);
    return int'(act_code[c*CW +: CW]);
  endfunction

  task automatic set_req(input int c0, input bit m0, input int c1, input bit m1);
    @(negedge clk);
    req_code = {CW'(c1), CW'(c0)};
    req_mute = {m1, m0};
  endtask

  task automatic push(input longint s0, input longint s1);
    @(negedge clk);
    in_data = {DW'(s1), DW'(s0)};
    in_stb = 1'b1;
    @(negedge clk);
    in_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    longint smp[7] = '{32767, -32768, 1, -1, 12345, -23456, 257};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 code0", acode(0), 0);
    chk("R1 code1", acode(1), 0);
    chk("R1 mute", act_mute, 0);
    chk("R1 vld", out_vld, 0);
    chk("R1 data", out_data, 0);
    rst_n = 1'b1;

    // R2 full code sweep, R4 zero sample applies
    for (int code = 0; code < 64; code++) begin
      set_req(code, 0, 63 - code, 0);
      push(0, 0);
      chk("R4 zero applies ch0", acode(0), code);
      chk("R4 zero applies ch1", acode(1), 63 - code);
      for (int i = 0; i < 7; i++) begin
        push(smp[i], -smp[i] - 1);
        chk("R2 gain ch0", outw(0), expv(smp[i], code));
        chk("R2 gain ch1", outw(1), expv(-smp[i] - 1, 63 - code));
      end
    end

    // R10 valid pulse timing
    push(100, 100);
    chk("R10 vld after stb", out_vld, 1);
    @(negedge clk);
    chk("R10 vld quiet", out_vld, 0);

    // R3 mute
    set_req(10, 1, 10, 0);
    push(0, 0);
    chk("R3 mute active", act_mute, 2'b01);
    push(5000, 5000);
    chk("R3 muted out", outw(0), 0);
    chk("R3 unmuted neighbour", outw(1), expv(5000, 10));
    push(-32768, -32768);
    chk("R3 muted out neg", outw(0), 0);
    set_req(10, 0, 10, 0);
    push(0, 0);
    chk("R3 unmute", act_mute, 0);

    // R4/R5 sign-change crossing
    push(1000, 1000);
    set_req(20, 0, 10, 0);
    for (int i = 0; i < 3; i++) begin
      push(1000, 1000);
      chk("R5 hold ch0", acode(0), 10);
      chk("R5 old gain", outw(0), expv(1000, 10));
    end
    repeat (5) @(negedge clk);
    chk("R5 idle hold", acode(0), 10);
    push(-5, 1000);
    chk("R4 sign crossing", acode(0), 20);
    chk("R4 new gain on crossing sample", outw(0), expv(-5, 20));
    chk("R9 ch1 untouched", acode(1), 10);
    set_req(30, 0, 10, 0);
    push(-7, 1000);
    chk("R5 neg no crossing", acode(0), 20);
    push(3, 1000);
    chk("R4 neg-to-pos crossing", acode(0), 30);

    // R6 timeout
    push(1000, 1000);
    set_req(40, 0, 10, 0);
    for (int i = 0; i < TO - 1; i++) push(1000, 1000);
    chk("R6 before deadline", acode(0), 30);
    push(1000, 1000);
    chk("R6 forced at deadline", acode(0), 40);
    chk("R6 gain at deadline", outw(0), expv(1000, 40));

    // R7 replacement keeps timer
    set_req(50, 0, 10, 0);
    for (int i = 0; i < 3; i++) push(1000, 1000);
    set_req(51, 0, 10, 0);
    for (int i = 0; i < TO - 4; i++) push(1000, 1000);
    chk("R7 before deadline", acode(0), 40);
    push(1000, 1000);
    chk("R7 latest at first deadline", acode(0), 51);

    // R8 withdrawal clears timer
    set_req(60, 0, 10, 0);
    for (int i = 0; i < 3; i++) push(1000, 1000);
    set_req(51, 0, 10, 0);
    set_req(60, 0, 10, 0);
    for (int i = 0; i < TO - 1; i++) push(1000, 1000);
    chk("R8 full window kept", acode(0), 51);
    push(1000, 1000);
    chk("R8 applied after full window", acode(0), 60);

    // R9 independence
    set_req(5, 0, 6, 0);
    push(0, 1000);
    chk("R9 ch0 applies", acode(0), 5);
    chk("R9 ch1 waits", acode(1), 10);
    push(1000, -1);
    chk("R9 ch1 applies", acode(1), 6);
    chk("R9 ch0 kept", acode(0), 5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule